// File: doc/BRIEF.md
# Host Clock Output with Shutdown Tail

This block produces the clock that a companion microcontroller runs from. While the reference oscillator is enabled, the output is the reference clock divided by a selectable even ratio. When the host clears the oscillator enable, the output does not stop at once. The block keeps requesting the crystal and emits a counted run of further pulses, called the tail, so that the host can finish its own shutdown. It then parks the output low.

After the tail, an optional slow sleep clock can be routed to the output. The slow clock is sampled into the reference domain through a synchronizer. Every change of source happens only while both the old and the new source are low. A divider ratio change takes effect only after the output falls. Raising the oscillator enable again during the tail cancels the tail without breaking the divided clock. Raising it during sleep hands the output back to the divider once the slow clock is low.

Top module: `clkout_gen`

## Requirements
- R1: While reset is held, clk_out is low and keep_alive is high. The first high phase after reset lasts DEF_SEL+1 reference cycles, whatever div_sel holds.
- R2: While running, each high phase and each low phase of clk_out lasts div_sel+1 reference cycles, giving a division ratio of 2*(div_sel+1).
- R3: A new div_sel is taken up only when clk_out falls. Across a change, every phase lasts either the old or the new half period and never less.
- R4: Once osc_en is sampled low, clk_out shows exactly N more rising edges and then stays low. N is tail_len, and a tail_len of 0 selects TAIL_DEF (128) pulses.
- R5: keep_alive stays high through running and through the tail. It falls in the cycle the output stops, with clk_out low at that point.
- R6: If osc_en returns high during the tail, the tail is abandoned, keep_alive never falls, and the divided clock continues with no phase longer or shorter than the half period.
- R7: After the tail, with slow_en high, clk_out follows the synchronized slow_clk with its phase widths kept. The output is handed to the slow clock only while that clock is low.
- R8: After the tail, with slow_en low, clk_out stays low whatever slow_clk does.
- R9: Raising osc_en during sleep hands clk_out back to the divider only while the slow clock is low and raises keep_alive. The divided clock restarts at the div_sel value present at that time, with no phase shorter than the smaller half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that clocks all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_clk | input | 1 | Slow sleep clock, asynchronous to ref_clk |
| div_sel | input | DIV_W | Half-period select: each phase lasts div_sel+1 reference cycles |
| osc_en | input | 1 | Oscillator enable from the host power control |
| slow_en | input | 1 | Route the slow clock to the output after the tail |
| tail_len | input | TAIL_W | Number of tail pulses, where 0 means TAIL_DEF |
| clk_out | output | 1 | Clock to the host |
| keep_alive | output | 1 | Request to keep the crystal oscillator running |

## Verification
On every cycle, the assertions check the following: the divider count stays inside the latched half period; the latched ratio holds steady through a high phase; a blocked rising slot leaves the output low; a cancelled tail returns to running; entries to and exits from the slow source happen only while the slow clock and the output are low; and the output is low when keep_alive falls. Only the bench scenarios can show the phase widths for each ratio, the exact number of tail pulses including the default length, the gap-free cancel, the widths of the routed slow clock, and the restart with a ratio that was changed during sleep.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_TAIL = 2'd1,
      ST_IDLE = 2'd2,
      ST_SLOW = 2'd3
   } clk_state_e;
endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkout_div.sv
module clkout_div #(
   parameter int DIV_W   = 3,
   parameter int DEF_SEL = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             hold_low,
   input  logic [DIV_W-1:0] sel,
   output logic             q,
   output logic             rise_slot
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lat;
   logic             tick;

   assign tick      = en && (cnt == lat);
   assign rise_slot = tick && !q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         q   <= 1'b0;
         lat <= DIV_W'(DEF_SEL);
      end else if (!en) begin
         cnt <= '0;
         q   <= 1'b0;
         lat <= sel;
      end else if (tick) begin
         cnt <= '0;
         if (q) begin
            q   <= 1'b0;
            lat <= sel;
         end else if (!hold_low) begin
            q <= 1'b1;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R2: the phase counter never runs past the latched half period
   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt <= lat));

   // R3: the ratio cannot move while the output is high
   p_lat_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && q) |-> $stable(lat));

   // R4: a blocked rising slot leaves the output low
   p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_slot && hold_low) |=> !q);
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
   import clkout_pkg::*;
#(
   parameter int TAIL_W   = 8,
   parameter int TAIL_DEF = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_en,
   input  logic              slow_req,
   input  logic              slow_s,
   input  logic              rise_slot,
   input  logic [TAIL_W-1:0] tail_len,
   output clk_state_e        state_o,
   output logic              hold_low
);
   clk_state_e        state;
   logic [TAIL_W-1:0] tail_cnt;
   logic [TAIL_W-1:0] target;

   assign target   = (tail_len == '0) ? TAIL_W'(TAIL_DEF) : tail_len;
   assign hold_low = (state == ST_TAIL) && !osc_en && (tail_cnt >= target);
   assign state_o  = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_RUN;
         tail_cnt <= '0;
      end else begin
         unique case (state)
            ST_RUN: begin
               tail_cnt <= '0;
               if (!osc_en) state <= ST_TAIL;
            end
            ST_TAIL: begin
               if (osc_en) begin
                  state <= ST_RUN;
               end else if (rise_slot) begin
                  if (hold_low) state <= ST_IDLE;
                  else          tail_cnt <= tail_cnt + 1'b1;
               end
            end
            ST_IDLE: begin
               if (osc_en)                    state <= ST_RUN;
               else if (slow_req && !slow_s)  state <= ST_SLOW;
            end
            ST_SLOW: begin
               if ((osc_en || !slow_req) && !slow_s) state <= ST_IDLE;
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   // R6: a re-enable seen during the tail returns straight to running
   p_cancel_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TAIL && osc_en) |=> (state == ST_RUN));

   // R7: the slow source is taken only while it is low
   p_slow_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_SLOW) |-> !$past(slow_s));

   // R9: the slow source is released only while it is low
   p_slow_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(state == ST_SLOW) |-> !$past(slow_s));
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
   import clkout_pkg::*;
#(
   parameter int DIV_W       = 3,
   parameter int DEF_SEL     = 4,
   parameter int TAIL_W      = 8,
   parameter int TAIL_DEF    = 128,
   parameter int SYNC_STAGES = 2,
   parameter bit USE_SLOW    = 1'b1
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              slow_clk,
   input  logic [DIV_W-1:0]  div_sel,
   input  logic              osc_en,
   input  logic              slow_en,
   input  logic [TAIL_W-1:0] tail_len,
   output logic              clk_out,
   output logic              keep_alive
);
   localparam int SEL_MAX  = (1 << DIV_W) - 1;
   localparam int TAIL_MAX = (1 << TAIL_W) - 1;

   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must lie between 1 and 8");
      end
      if (DEF_SEL < 0 || DEF_SEL > SEL_MAX) begin : g_bad_def
         $error("DEF_SEL does not fit in DIV_W bits");
      end
      if (TAIL_DEF < 1 || TAIL_DEF > TAIL_MAX) begin : g_bad_tail
         $error("TAIL_DEF must be nonzero and fit in TAIL_W bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   clk_state_e st;
   logic       div_q;
   logic       rise_slot;
   logic       hold_low;
   logic       slow_s;
   logic       slow_req;
   logic       div_en;

   generate
      if (USE_SLOW) begin : g_slow
         clkout_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (ref_clk),
            .rst_n (rst_n),
            .d     (slow_clk),
            .q     (slow_s)
         );
         assign slow_req = slow_en;
      end else begin : g_noslow
         assign slow_s   = 1'b0;
         assign slow_req = 1'b0;
      end
   endgenerate

   assign div_en = (st == ST_RUN) || (st == ST_TAIL);

   clkout_div #(.DIV_W(DIV_W), .DEF_SEL(DEF_SEL)) u_div (
      .clk       (ref_clk),
      .rst_n     (rst_n),
      .en        (div_en),
      .hold_low  (hold_low),
      .sel       (div_sel),
      .q         (div_q),
      .rise_slot (rise_slot)
   );

   clkout_ctrl #(.TAIL_W(TAIL_W), .TAIL_DEF(TAIL_DEF)) u_ctrl (
      .clk       (ref_clk),
      .rst_n     (rst_n),
      .osc_en    (osc_en),
      .slow_req  (slow_req),
      .slow_s    (slow_s),
      .rise_slot (rise_slot),
      .tail_len  (tail_len),
      .state_o   (st),
      .hold_low  (hold_low)
   );

   always_comb begin
      if (div_en)             clk_out = div_q;
      else if (st == ST_SLOW) clk_out = slow_s;
      else                    clk_out = 1'b0;
   end

   assign keep_alive = div_en;

   // R5: the crystal request drops only with the output low
   p_stop_low_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(keep_alive) |-> (!clk_out && !$past(clk_out)));

   // R8: the parked state drives nothing
   p_idle_quiet_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !clk_out);

   // R7: switching in or out of the slow source happens on a low output
   p_switch_low_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ($rose(st == ST_SLOW) || $fell(st == ST_SLOW)) |-> !$past(clk_out));
endmodule

// File: tb/clkout_gen_test.sv
module clkout_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV_W      = 3;
   localparam int TAIL_W     = 8;
   localparam int DEF_SEL    = 4;
   localparam int TAIL_DEF   = 128;
   localparam int SLOW_HALF  = 7;

   logic              ref_clk = 1'b0;
   logic              rst_n   = 1'b0;
   logic              slow_clk = 1'b0;
   logic [DIV_W-1:0]  div_sel = 3'd1;
   logic              osc_en  = 1'b1;
   logic              slow_en = 1'b0;
   logic [TAIL_W-1:0] tail_len = 8'd5;
   logic              clk_out;
   logic              keep_alive;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   clkout_gen #(.DIV_W(DIV_W), .DEF_SEL(DEF_SEL), .TAIL_W(TAIL_W),
                .TAIL_DEF(TAIL_DEF)) uut (
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .slow_clk   (slow_clk),
      .div_sel    (div_sel),
      .osc_en     (osc_en),
      .slow_en    (slow_en),
      .tail_len   (tail_len),
      .clk_out    (clk_out),
      .keep_alive (keep_alive)
   );

   always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

   initial begin
      forever begin
         repeat (SLOW_HALF) @(negedge ref_clk);
         slow_clk = ~slow_clk;
      end
   end

   function automatic int exp_half(input int sel);
      return sel + 1;
   endfunction

   function automatic int exp_tail(input int len);
      return (len == 0) ? TAIL_DEF : len;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // complete phases only: the first partial run is dropped
   task automatic watch(input int cycles, output int hmin, output int hmax,
                        output int lmin, output int lmax, output int rises);
      logic prev;
      int   run;
      bit   seen;
      hmin = 9999; hmax = 0; lmin = 9999; lmax = 0; rises = 0;
      @(negedge ref_clk);
      prev = clk_out; run = 1; seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge ref_clk);
         if (clk_out == prev) begin
            run++;
         end else begin
            if (seen) begin
               if (prev) begin
                  if (run < hmin) hmin = run;
                  if (run > hmax) hmax = run;
               end else begin
                  if (run < lmin) lmin = run;
                  if (run > lmax) lmax = run;
               end
            end
            seen = 1;
            if (clk_out) rises++;
            prev = clk_out;
            run  = 1;
         end
      end
   endtask

   task automatic run_tail(input int expect_n);
      logic prev;
      int   cnt;
      bit   stopped;
      @(negedge ref_clk);
      osc_en = 1'b0;
      @(negedge ref_clk);
      prev = clk_out; cnt = 0; stopped = 0;
      for (int i = 0; i < 6000 && !stopped; i++) begin
         @(negedge ref_clk);
         if (clk_out && !prev) cnt++;
         prev = clk_out;
         if (!keep_alive) stopped = 1;
      end
      check(stopped == 1, "R5 keep_alive falls after tail", int'(stopped), 1);
      check(cnt == expect_n, "R4 tail pulse count", cnt, expect_n);
      check(clk_out == 1'b0, "R5 output low at stop", int'(clk_out), 0);
   endtask

   task automatic wake();
      @(negedge ref_clk);
      osc_en = 1'b1;
      for (int i = 0; i < 100 && !keep_alive; i++) @(negedge ref_clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int hmin, hmax, lmin, lmax, rises, sel_a, sel_b, hw, len, seed;
      bit ka_ok;
      seed = $urandom(32'd2024);

      // R1: reset state
      repeat (3) @(negedge ref_clk);
      check(clk_out == 1'b0, "R1 reset clk_out", int'(clk_out), 0);
      check(keep_alive == 1'b1, "R1 reset keep_alive", int'(keep_alive), 1);
      rst_n = 1'b1;
      while (!clk_out) @(negedge ref_clk);
      hw = 0;
      while (clk_out) begin hw++; @(negedge ref_clk); end
      check(hw == exp_half(DEF_SEL), "R1 first high phase uses default", hw, exp_half(DEF_SEL));

      // R2: directed then random ratios
      watch(40, hmin, hmax, lmin, lmax, rises);
      watch(80, hmin, hmax, lmin, lmax, rises);
      check(hmin == 2 && hmax == 2 && lmin == 2 && lmax == 2, "R2 half period sel=1", hmax, 2);
      for (int k = 0; k < 5; k++) begin
         sel_a = $urandom % 8;
         div_sel = DIV_W'(sel_a);
         watch(40, hmin, hmax, lmin, lmax, rises);
         watch(80, hmin, hmax, lmin, lmax, rises);
         check(hmin == exp_half(sel_a) && hmax == exp_half(sel_a) &&
               lmin == exp_half(sel_a) && lmax == exp_half(sel_a),
               "R2 half period random", lmax, exp_half(sel_a));
      end

      // R3: ratio change mid-phase never makes a runt
      for (int k = 0; k < 3; k++) begin
         sel_a = $urandom % 8;
         sel_b = $urandom % 8;
         div_sel = DIV_W'(sel_a);
         watch(40, hmin, hmax, lmin, lmax, rises);
         repeat ($urandom % 9) @(negedge ref_clk);
         div_sel = DIV_W'(sel_b);
         watch(60, hmin, hmax, lmin, lmax, rises);
         hw = (sel_a < sel_b) ? sel_a : sel_b;
         check(hmin >= exp_half(hw) && lmin >= exp_half(hw), "R3 no short phase",
               (hmin < lmin) ? hmin : lmin, exp_half(hw));
         hw = (sel_a > sel_b) ? sel_a : sel_b;
         check(hmax <= exp_half(hw) && lmax <= exp_half(hw), "R3 no long phase",
               (hmax > lmax) ? hmax : lmax, exp_half(hw));
      end

      // R4, R5, R8: directed tail, parked output ignores slow_clk
      div_sel = 3'd2; tail_len = 8'd5; slow_en = 1'b0;
      watch(20, hmin, hmax, lmin, lmax, rises);
      run_tail(exp_tail(5));
      watch(100, hmin, hmax, lmin, lmax, rises);
      check(rises == 0 && clk_out == 1'b0, "R8 parked output stays low", rises, 0);
      check(keep_alive == 1'b0, "R5 keep_alive low when parked", int'(keep_alive), 0);
      wake();

      // R4: random tails and the default length
      for (int k = 0; k < 2; k++) begin
         len = 1 + ($urandom % 40);
         div_sel = DIV_W'($urandom % 8);
         tail_len = TAIL_W'(len);
         watch(30, hmin, hmax, lmin, lmax, rises);
         run_tail(exp_tail(len));
         wake();
      end
      div_sel = 3'd0; tail_len = 8'd0;
      watch(20, hmin, hmax, lmin, lmax, rises);
      run_tail(exp_tail(0));
      wake();

      // R6: cancel during the tail
      div_sel = 3'd3; tail_len = 8'd50;
      watch(30, hmin, hmax, lmin, lmax, rises);
      ka_ok = 1;
      fork
         watch(150, hmin, hmax, lmin, lmax, rises);
         begin
            repeat (20) @(negedge ref_clk);
            osc_en = 1'b0;
            for (int i = 0; i < 30; i++) begin
               @(negedge ref_clk);
               if (!keep_alive) ka_ok = 0;
            end
            osc_en = 1'b1;
         end
      join
      check(ka_ok == 1 && keep_alive == 1'b1, "R6 keep_alive held on cancel", int'(ka_ok), 1);
      check(hmin == 4 && hmax == 4 && lmin == 4 && lmax == 4, "R6 no gap on cancel",
            (lmax > hmax) ? lmax : hmax, 4);

      // R7: sleep clock after tail
      div_sel = 3'd0; tail_len = 8'd3; slow_en = 1'b1;
      watch(20, hmin, hmax, lmin, lmax, rises);
      run_tail(exp_tail(3));
      watch(200, hmin, hmax, lmin, lmax, rises);
      check(hmin == SLOW_HALF && hmax == SLOW_HALF, "R7 slow high width", hmax, SLOW_HALF);
      check(lmin == SLOW_HALF && lmax == SLOW_HALF, "R7 slow low width", lmax, SLOW_HALF);
      check(rises >= 12 && keep_alive == 1'b0, "R7 slow clock routed", rises, 14);

      // R9: wake from sleep with a ratio changed while asleep
      div_sel = 3'd3;
      fork
         watch(80, hmin, hmax, lmin, lmax, rises);
         begin
            repeat (11) @(negedge ref_clk);
            osc_en = 1'b1;
         end
      join
      check(keep_alive == 1'b1, "R9 keep_alive back on wake", int'(keep_alive), 1);
      check(hmin >= 4 && lmin >= 4, "R9 no short phase on handover",
            (hmin < lmin) ? hmin : lmin, 4);
      watch(80, hmin, hmax, lmin, lmax, rises);
      check(hmin == 4 && hmax == 4 && lmin == 4 && lmax == 4, "R9 held ratio after wake",
            hmax, 4);

      finish_run();
   end
endmodule